// File: doc/BRIEF.md
# Adaptive Supply Voltage Loop Controller

This block closes a discrete-time feedback loop around silicon speed. An on-chip performance monitor delivers a digital word that rises with the speed the logic reaches at the present supply and clock. Each time that word is strobed in, the controller compares it against a programmable target word and moves an 8-bit supply request code. The request code goes to a serial power-interface master, which forwards it to the regulator. The monitor, the serial link and the regulator are outside this block.

The correction is the signed error (target minus measurement) divided by a power of two. The divisor is a right-shift amount, and it is programmed separately for upward and downward moves. This lets the supply rise quickly when more speed is needed and come down gently, so that it does not undershoot. The request is clamped between programmable floor and ceiling codes. When the error is inside a programmable deadband, the request is frozen. A settled flag rises once the error has stayed in that band for a programmable number of consecutive samples, so frequency changes can be handed off as soon as the supply is ready. After the configuration inputs are set, the loop runs without software.

Top module: `vloop_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, `vreq` becomes `cfg_floor` and `settled` becomes 0.
- R2: The error is the signed value `cfg_target - perf_word`, with both taken as unsigned. `vreq` and `settled` change only in the cycle after a clock edge at which `perf_vld` is high. With `perf_vld` low, both keep their values.
- R3: On a sample whose error is positive and outside the deadband, `vreq` moves by the error arithmetically shifted right by `cfg_shift_up` (0 to 7).
- R4: On a sample whose error is negative and outside the deadband, `vreq` moves by the error arithmetically shifted right by `cfg_shift_dn` (0 to 7). The result rounds toward minus infinity, so a negative error always lowers the code by at least 1.
- R5: The updated request is clamped into [`cfg_floor`, `cfg_ceil`]. It never wraps past 0 or 255.
- R6: When |error| <= `cfg_band`, a sample leaves `vreq` unchanged.
- R7: `settled` is 1 after the latest sample if that sample and the ones before it, consecutively, were in band, at least `cfg_count` times in a row. A `cfg_count` of 0 acts as 1, and the run counter stops at 15.
- R8: A sample outside the band clears `settled` and restarts the run count in the cycle after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_target | input | 10 | Target performance word |
| cfg_shift_up | input | 3 | Right shift applied to positive errors |
| cfg_shift_dn | input | 3 | Right shift applied to negative errors |
| cfg_floor | input | 8 | Lowest request code |
| cfg_ceil | input | 8 | Highest request code |
| cfg_band | input | 10 | Deadband on absolute error |
| cfg_count | input | 4 | In-band samples needed before settled |
| perf_vld | input | 1 | Sample strobe for perf_word |
| perf_word | input | 10 | Measured performance word |
| vreq | output | 8 | Supply request code |
| settled | output | 1 | Error has stayed in band long enough |

## Verification
The hardest condition to reach from the ports is a request that has been pushed against a clamp and then held by the deadband while the configuration changes underneath it. The bench reaches it with a randomized phase that reprograms the floor, ceiling, band and shifts between sample bursts. A second hard case is a run of in-band samples with idle gaps between them. The bench produces this with a simple plant model that feeds the request back into the performance word, so the loop converges by itself, and with random strobe spacing on top. Separate directed bursts with a large error of each sign drive the code into both clamps.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

    typedef enum logic [1:0] {
        CORR_HOLD = 2'd0,
        CORR_UP   = 2'd1,
        CORR_DOWN = 2'd2
    } corr_e;

    typedef struct packed {
        corr_e dir;
        logic  inband;
    } err_info_t;

    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vloop_err.sv
module vloop_err
    import vloop_pkg::*;
#(
    parameter int unsigned PERF_W  = 10,
    parameter int unsigned SHIFT_W = 3,
    parameter int unsigned EW      = PERF_W + 1
) (
    input  logic [PERF_W-1:0]  target,
    input  logic [PERF_W-1:0]  perf,
    input  logic [PERF_W-1:0]  band,
    input  logic [SHIFT_W-1:0] shift_up,
    input  logic [SHIFT_W-1:0] shift_dn,
    output logic signed [EW-1:0] step,
    output err_info_t          info
);
    logic signed [EW-1:0] err;
    logic [EW-1:0]        mag;
    logic [SHIFT_W-1:0]   shamt;

    always_comb begin
        err   = $signed({1'b0, target}) - $signed({1'b0, perf});
        mag   = err[EW-1] ? $unsigned(-err) : $unsigned(err);
        info.inband = (mag <= {1'b0, band});
        if (info.inband)
            info.dir = CORR_HOLD;
        else if (err[EW-1])
            info.dir = CORR_DOWN;
        else
            info.dir = CORR_UP;
        shamt = err[EW-1] ? shift_dn : shift_up;
        step  = err >>> shamt;
    end

endmodule

// File: rtl/vloop_accum.sv
module vloop_accum
    import vloop_pkg::*;
#(
    parameter int unsigned REQ_W = 8,
    parameter int unsigned EW    = 11,
    parameter int unsigned SW    = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  err_info_t            info,
    input  logic signed [EW-1:0] step,
    input  logic [REQ_W-1:0]     floor_code,
    input  logic [REQ_W-1:0]     ceil_code,
    output logic [REQ_W-1:0]     vreq
);
    logic signed [SW-1:0] sum, lo, hi;
    logic [REQ_W-1:0]     next_req;

    always_comb begin
        lo  = $signed({{(SW-REQ_W){1'b0}}, floor_code});
        hi  = $signed({{(SW-REQ_W){1'b0}}, ceil_code});
        sum = $signed({{(SW-REQ_W){1'b0}}, vreq}) + $signed({{(SW-EW){step[EW-1]}}, step});
        if (sum > hi)
            next_req = ceil_code;
        else if (sum < lo)
            next_req = floor_code;
        else
            next_req = sum[REQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            vreq <= floor_code;
        else if (smp_valid && !info.inband)
            vreq <= next_req;
    end

    AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !info.inband && floor_code <= ceil_code) |=>
        (vreq >= $past(floor_code) && vreq <= $past(ceil_code))); // R5

    AST_BAND_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && info.inband) |=> $stable(vreq)); // R6

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(vreq)); // R2

    AST_RISE_MONO: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && info.dir == CORR_UP && vreq >= floor_code && vreq <= ceil_code) |=>
        vreq >= $past(vreq)); // R3

    AST_FALL_MONO: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && info.dir == CORR_DOWN && vreq > floor_code && vreq <= ceil_code) |=>
        vreq < $past(vreq)); // R4

endmodule

// File: rtl/vloop_settle.sv
module vloop_settle #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             inband,
    input  logic [CNT_W-1:0] need_cfg,
    output logic             settled
);
    logic [CNT_W-1:0] run_cnt, run_inc, need;

    always_comb begin
        run_inc = (run_cnt == {CNT_W{1'b1}}) ? run_cnt : run_cnt + 1'b1;
        need    = (need_cfg == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : need_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            settled <= 1'b0;
        end else if (smp_valid) begin
            if (inband) begin
                run_cnt <= run_inc;
                settled <= (run_inc >= need);
            end else begin
                run_cnt <= '0;
                settled <= 1'b0;
            end
        end
    end

    AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !inband) |=> !settled); // R8

    AST_SETTLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(settled)); // R2

    AST_SETTLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> $past(smp_valid && inband)); // R7

endmodule

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
    import vloop_pkg::*;
#(
    parameter int unsigned PERF_W  = 10,
    parameter int unsigned REQ_W   = 8,
    parameter int unsigned SHIFT_W = 3,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PERF_W-1:0]  cfg_target,
    input  logic [SHIFT_W-1:0] cfg_shift_up,
    input  logic [SHIFT_W-1:0] cfg_shift_dn,
    input  logic [REQ_W-1:0]   cfg_floor,
    input  logic [REQ_W-1:0]   cfg_ceil,
    input  logic [PERF_W-1:0]  cfg_band,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               perf_vld,
    input  logic [PERF_W-1:0]  perf_word,
    output logic [REQ_W-1:0]   vreq,
    output logic               settled
);
    localparam int unsigned EW = PERF_W + 1;
    localparam int unsigned SW = wmax(EW, REQ_W) + 2;

    logic signed [EW-1:0] step;
    err_info_t            info;

    vloop_err #(.PERF_W(PERF_W), .SHIFT_W(SHIFT_W), .EW(EW)) u_err (
        .target   (cfg_target),
        .perf     (perf_word),
        .band     (cfg_band),
        .shift_up (cfg_shift_up),
        .shift_dn (cfg_shift_dn),
        .step     (step),
        .info     (info)
    );

    vloop_accum #(.REQ_W(REQ_W), .EW(EW), .SW(SW)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (perf_vld),
        .info       (info),
        .step       (step),
        .floor_code (cfg_floor),
        .ceil_code  (cfg_ceil),
        .vreq       (vreq)
    );

    vloop_settle #(.CNT_W(CNT_W)) u_set (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (perf_vld),
        .inband    (info.inband),
        .need_cfg  (cfg_count),
        .settled   (settled)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (vreq == $past(cfg_floor) && !settled)); // R1

endmodule

// File: tb/sim_vloop_ctrl.sv
`timescale 1ns/1ps
module sim_vloop_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] cfg_target, cfg_band, perf_word;
    logic [2:0] cfg_shift_up, cfg_shift_dn;
    logic [7:0] cfg_floor, cfg_ceil;
    logic [3:0] cfg_count;
    logic       perf_vld;
    logic [7:0] vreq;
    logic       settled;

    int    n_chk = 0, n_bad = 0;
    bit    started = 0, done = 0;
    int    m_req, m_cnt;
    bit    m_set;
    string tag_r, tag_s;

    always #4 clk = ~clk;

    vloop_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_target(cfg_target), .cfg_shift_up(cfg_shift_up),
        .cfg_shift_dn(cfg_shift_dn), .cfg_floor(cfg_floor), .cfg_ceil(cfg_ceil),
        .cfg_band(cfg_band), .cfg_count(cfg_count), .perf_vld(perf_vld),
        .perf_word(perf_word), .vreq(vreq), .settled(settled)
    );

    // behavioural reference model
    always @(posedge clk) begin
        int e, ae, sh, s, need;
        if (rst) begin
            m_req = cfg_floor; m_cnt = 0; m_set = 0;
            tag_r = "R1"; tag_s = "R1";
        end else if (perf_vld) begin
            e  = int'(cfg_target) - int'(perf_word);
            ae = (e < 0) ? -e : e;
            if (ae <= int'(cfg_band)) begin
                tag_r = "R6";
                m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
                need  = (cfg_count == 0) ? 1 : int'(cfg_count);
                m_set = (m_cnt >= need);
                tag_s = "R7";
            end else begin
                sh    = (e > 0) ? int'(cfg_shift_up) : int'(cfg_shift_dn);
                s     = m_req + (e >>> sh);
                tag_r = (e > 0) ? "R3" : "R4";
                if (s > int'(cfg_ceil)) begin s = cfg_ceil; tag_r = "R5"; end
                else if (s < int'(cfg_floor)) begin s = cfg_floor; tag_r = "R5"; end
                m_req = s; m_cnt = 0; m_set = 0;
                tag_s = "R8";
            end
        end else begin
            tag_r = "R2"; tag_s = "R2";
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_chk += 2;
            if (int'(vreq) != m_req) begin
                n_bad++;
                $display("FAIL %s vreq actual=%0d expected=%0d t=%0t", tag_r, vreq, m_req, $time);
            end
            if (settled != m_set) begin
                n_bad++;
                $display("FAIL %s settled actual=%0d expected=%0d t=%0t", tag_s, settled, m_set, $time);
            end
        end
    end

    task automatic sample(input int p);
        @(negedge clk);
        perf_vld  = 1'b1;
        perf_word = 10'(p);
        @(negedge clk);
        perf_vld  = 1'b0;
    endtask

    // simple plant: speed grows with the request code
    task automatic plant(input int n, input int off, input int gap);
        for (int i = 0; i < n; i++) begin
            int p;
            p = 2 * int'(vreq) + off;
            if (p > 1023) p = 1023;
            if (p < 0) p = 0;
            sample(p);
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; perf_vld = 1'b0; perf_word = '0;
        cfg_target = 10'd500; cfg_shift_up = 3'd1; cfg_shift_dn = 3'd3;
        cfg_floor = 8'd20; cfg_ceil = 8'd200; cfg_band = 10'd4; cfg_count = 4'd3;
        @(negedge clk); started = 1;            // R1 reset state checked here
        repeat (3) @(negedge clk);
        rst = 1'b0;
        plant(12, 140, 2);                      // R3 fast rise, R7 settle
        cfg_target = 10'd300;
        plant(30, 140, 1);                      // R4 gentle fall, R6 hold
        repeat (5) @(negedge clk);              // R2 idle
        cfg_target = 10'd1023; sample(0); sample(0); sample(0);   // R5 ceiling
        cfg_target = 10'd0; sample(1023); sample(1023); sample(1023); // R5 floor
        cfg_ceil = 8'd255; cfg_floor = 8'd0; cfg_shift_up = 3'd0; cfg_shift_dn = 3'd0;
        cfg_target = 10'd1023; sample(0); sample(0); sample(0);   // R5 no wrap high
        cfg_target = 10'd0; sample(1023); sample(1023);           // R5 no wrap low
        cfg_target = 10'd5; cfg_band = 10'd0; cfg_shift_dn = 3'd7; sample(6); // R4 floor rounding
        cfg_count = 4'd0; sample(5); sample(5);                   // R7 count 0 acts as 1
        cfg_count = 4'd15; for (int i = 0; i < 20; i++) sample(5); // R7 long run, saturating count
        sample(9);                                                 // R8 drop
        rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;   // R1 again
        for (int k = 0; k < 3000; k++) begin
            if ((k % 97) == 0) begin
                cfg_shift_up = 3'($urandom % 8); cfg_shift_dn = 3'($urandom % 8);
                cfg_floor = 8'($urandom % 100);
                cfg_ceil  = 8'(int'(cfg_floor) + int'($urandom % 156));
                cfg_band  = 10'($urandom % 16); cfg_count = 4'($urandom % 16);
                cfg_target = 10'(200 + $urandom % 400);
            end
            @(negedge clk);
            perf_vld = ($urandom % 3) != 0;
            if ((k % 5) == 0) perf_word = 10'($urandom % 1024);
            else begin
                int p;
                p = 2 * int'(vreq) + 150 + int'($urandom % 7) - 3;
                perf_word = 10'((p > 1023) ? 1023 : p);
            end
        end
        @(negedge clk); perf_vld = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule